// File: doc/BRIEF.md
# Sampled Angle Serial Readout Port

This block keeps a snapshot of a tracking converter's live angle and speed words and reads one of them out over a three-wire serial link. The link has an active-low frame/enable input, a serial clock input and a serial data output. A falling edge on the sample strobe copies both live words into holding registers. Reads then return those held values while the converter keeps running and updating its live words.

A read begins when the read input falls while chip select is low. That edge loads a 16-bit frame into the output shifter and enables the data pin. The frame holds four fields:
- the selected 12-bit word, either unsigned position or two's-complement velocity;
- a flag that says which word was chosen;
- the signal-degradation flag and the tracking-loss flag, taken at the moment of the read;
- an odd-parity bit.

The most significant bit is on the pin before the first serial clock edge. Each rising serial clock edge moves the next bit onto the pin. After all 16 bits have been sent, further edges shift out zeros.

All strobes and the serial clock are asynchronous to the system clock. Each passes through a two-flop synchroniser, and edges are found on the synchronised copies.

Top module: `angle_serial_port`

## Requirements
- R1: Both live words are copied into holding registers on a falling edge of `smp_strobe`. Changes of `pos_live` or `vel_live` after that edge do not alter a frame read later.
- R2: With `sel_pos` high the frame carries the held position word, and frame bit 3 is 1. With `sel_pos` low it carries the held velocity word, and bit 3 is 0.
- R3: The frame layout is as follows: bits 15..4 hold the 12-bit word, MSB in bit 15; bit 3 is the select flag; bit 2 is `flt_degrade`; bit 1 is `flt_trk_loss`.
- R4: Bit 0 is set so that the 16-bit frame always contains an odd number of ones.
- R5: A falling edge of `rd_n` while `cs_n` is low loads the frame and raises `sdo_oe`. Frame bit 15 is on `sdo` before any serial clock edge.
- R6: Each rising `ser_clk` edge presents the next lower frame bit on `sdo`, so the 16 bits leave MSB first.
- R7: While `rd_n` stays low after all 16 bits, each further rising `ser_clk` edge presents 0.
- R8: `sdo_oe` is low, and `sdo` is high impedance, whenever `rd_n` or `cs_n` is high. A falling `rd_n` while `cs_n` is high starts no frame.
- R9: The select and fault flags in the frame are those present at the read falling edge. Later changes of these inputs do not alter the frame in flight.
- R10: After reset `sdo_oe` is low and both holding registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_live | input | 12 | Live unsigned angle word |
| vel_live | input | 12 | Live two's-complement velocity word |
| smp_strobe | input | 1 | Sample strobe, captures on falling edge |
| sel_pos | input | 1 | 1 selects position, 0 selects velocity |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low frame start and output enable |
| ser_clk | input | 1 | Serial clock from the reader |
| flt_degrade | input | 1 | Signal-degradation fault flag |
| flt_trk_loss | input | 1 | Tracking-loss fault flag |
| sdo | output | 1 | Serial data, high impedance when idle |
| sdo_oe | output | 1 | Drive enable of `sdo` |

## Verification
The hardest case to reach from the ports is a frame whose content differs from what the inputs show at the moment each bit is observed. The bench reaches it inside every frame of its sweep. It changes the live words after sampling and before the read. It also flips the select and fault inputs after the read edge while the bits are still being clocked out. A frame that came from live data or from late flag values would then mismatch. The sweep also covers the all-zero and all-one words, keeps clocking past the sixteenth bit to check the zero tail, and drops `rd_n` with chip select high.

// File: rtl/aps_pkg.sv
package aps_pkg;
  // positions in the synchronised control vector
  localparam int SY_SAMPLE = 0;
  localparam int SY_RD     = 1;
  localparam int SY_CS     = 2;
  localparam int SY_SCLK   = 3;
  localparam int SY_SEL    = 4;
  localparam int SY_DEG    = 5;
  localparam int SY_LOT    = 6;
  localparam int SY_W      = 7;
  // idle levels: strobe, read and select idle high
  localparam logic [SY_W-1:0] SY_IDLE = 7'b000_0111;
  // trailer bits after the payload word
  localparam int TRAILER_W = 4;
endpackage

// File: rtl/aps_sync.sv
module aps_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] chain_d [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb chain_d[g] = d;
      end else begin : g_rest
        always_comb chain_d[g] = chain_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= RST_VAL;
        else        chain_q[g] <= chain_d[g];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/aps_capture.sv
module aps_capture #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] pos_in,
  input  logic [DATA_W-1:0] vel_in,
  output logic [DATA_W-1:0] pos_q,
  output logic [DATA_W-1:0] vel_q
);
  logic [DATA_W-1:0] pos_d, vel_d;

  always_comb begin
    pos_d = pos_q;
    vel_d = vel_q;
    if (cap_en) begin
      pos_d = pos_in;
      vel_d = vel_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      vel_q <= '0;
    end else begin
      pos_q <= pos_d;
      vel_q <= vel_d;
    end
  end
endmodule

// File: rtl/aps_frame_shift.sv
module aps_frame_shift
  import aps_pkg::*;
#(
  parameter int DATA_W  = 12,
  localparam int FRAME_W = DATA_W + TRAILER_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift,
  input  logic               drop,
  input  logic [DATA_W-1:0]  word,
  input  logic               sel_flag,
  input  logic               deg_flag,
  input  logic               lot_flag,
  output logic               sdo_bit,
  output logic               active,
  output logic [FRAME_W-1:0] shreg
);
  logic [FRAME_W-2:0] payload;
  logic               par_bit;
  logic [FRAME_W-1:0] shreg_d;
  logic               active_d;

  assign payload = {word, sel_flag, deg_flag, lot_flag};
  assign par_bit = ~(^payload);

  always_comb begin
    shreg_d  = shreg;
    active_d = active;
    if (load) begin
      shreg_d  = {payload, par_bit};
      active_d = 1'b1;
    end else if (drop) begin
      active_d = 1'b0;
    end else if (active && shift) begin
      shreg_d = {shreg[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      active <= 1'b0;
    end else begin
      shreg  <= shreg_d;
      active <= active_d;
    end
  end

  assign sdo_bit = shreg[FRAME_W-1];
endmodule

// File: rtl/angle_serial_port.sv
module angle_serial_port
  import aps_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pos_live,
  input  logic [DATA_W-1:0] vel_live,
  input  logic              smp_strobe,
  input  logic              sel_pos,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              ser_clk,
  input  logic              flt_degrade,
  input  logic              flt_trk_loss,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int FRAME_W = DATA_W + TRAILER_W;

  logic [SY_W-1:0]    raw_ctl, sync_q;
  logic [2:0]         prev_q, prev_d;
  logic               samp_s, rd_s, cs_s, sclk_s;
  logic               samp_fall, rd_fall, sclk_rise, load, drop;
  logic [DATA_W-1:0]  pos_q, vel_q, word_sel;
  logic               sdo_bit;
  logic [FRAME_W-1:0] shreg;

  always_comb begin
    raw_ctl          = '0;
    raw_ctl[SY_SAMPLE] = smp_strobe;
    raw_ctl[SY_RD]     = rd_n;
    raw_ctl[SY_CS]     = cs_n;
    raw_ctl[SY_SCLK]   = ser_clk;
    raw_ctl[SY_SEL]    = sel_pos;
    raw_ctl[SY_DEG]    = flt_degrade;
    raw_ctl[SY_LOT]    = flt_trk_loss;
  end

  aps_sync #(.W(SY_W), .STAGES(SYNC_STAGES), .RST_VAL(SY_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_ctl), .q(sync_q)
  );

  assign samp_s = sync_q[SY_SAMPLE];
  assign rd_s   = sync_q[SY_RD];
  assign cs_s   = sync_q[SY_CS];
  assign sclk_s = sync_q[SY_SCLK];

  // edge history: {sclk, rd, sample}
  assign prev_d = {sclk_s, rd_s, samp_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 3'b011;
    else        prev_q <= prev_d;
  end

  assign samp_fall = prev_q[0] & ~samp_s;
  assign rd_fall   = prev_q[1] & ~rd_s;
  assign sclk_rise = ~prev_q[2] & sclk_s;
  assign load      = rd_fall & ~cs_s;
  assign drop      = rd_s | cs_s;

  aps_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(samp_fall),
    .pos_in(pos_live), .vel_in(vel_live),
    .pos_q(pos_q), .vel_q(vel_q)
  );

  assign word_sel = sync_q[SY_SEL] ? pos_q : vel_q;

  aps_frame_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(load), .shift(sclk_rise), .drop(drop),
    .word(word_sel), .sel_flag(sync_q[SY_SEL]),
    .deg_flag(sync_q[SY_DEG]), .lot_flag(sync_q[SY_LOT]),
    .sdo_bit(sdo_bit), .active(sdo_oe), .shreg(shreg)
  );

  assign sdo = sdo_oe ? sdo_bit : 1'bz;
endmodule

// File: rtl/aps_checker.sv
module aps_checker #(
  parameter int DATA_W  = 12,
  parameter int FRAME_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_s,
  input logic               cs_s,
  input logic               samp_fall,
  input logic               sclk_rise,
  input logic               load,
  input logic               sdo_oe,
  input logic               sdo_bit,
  input logic [FRAME_W-1:0] shreg,
  input logic [DATA_W-1:0]  pos_q,
  input logic [DATA_W-1:0]  vel_q
);
  logic [5:0] shift_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     shift_cnt <= '0;
    else if (load)                                  shift_cnt <= '0;
    else if (sdo_oe && sclk_rise && !rd_s && !cs_s && shift_cnt != 6'h3f)
                                                    shift_cnt <= shift_cnt + 6'd1;
  end

  // R1: holding registers only move on a sample edge
  a_r1_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_fall |=> ($stable(pos_q) && $stable(vel_q)));

  // R4: a freshly loaded frame has odd weight
  a_r4_odd_frame: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (^shreg == 1'b1));

  // R5: a load enables the output
  a_r5_load_enables: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sdo_oe);

  // R6: frame content only moves on a serial clock rising edge or a load
  a_r6_shift_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && !sclk_rise && !load) |=> $stable(shreg));

  // R7: beyond sixteen shifts the pin carries zero
  a_r7_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && shift_cnt >= 6'(FRAME_W)) |-> !sdo_bit);

  // R8: read or select high turns the driver off
  a_r8_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_s || cs_s) && !load) |=> !sdo_oe);
endmodule

bind angle_serial_port aps_checker #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_s(rd_s), .cs_s(cs_s),
  .samp_fall(samp_fall), .sclk_rise(sclk_rise), .load(load),
  .sdo_oe(sdo_oe), .sdo_bit(sdo_bit), .shreg(shreg),
  .pos_q(pos_q), .vel_q(vel_q)
);

// File: tb/test_angle_serial_port.sv
module test_angle_serial_port;
  localparam int DW   = 12;
  localparam int FW   = 16;
  localparam int HALF = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] pos_live = '0, vel_live = '0;
  logic          smp_strobe = 1'b1, sel_pos = 1'b1, cs_n = 1'b1, rd_n = 1'b1;
  logic          ser_clk = 1'b0, flt_degrade = 1'b0, flt_trk_loss = 1'b0;
  wire           sdo;
  logic          sdo_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  angle_serial_port i_angle_serial_port (
    .clk(clk), .rst_n(rst_n), .pos_live(pos_live), .vel_live(vel_live),
    .smp_strobe(smp_strobe), .sel_pos(sel_pos), .cs_n(cs_n), .rd_n(rd_n),
    .ser_clk(ser_clk), .flt_degrade(flt_degrade), .flt_trk_loss(flt_trk_loss),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk_frame(input logic [DW-1:0] w, input logic s,
                                             input logic d, input logic l);
    logic [FW-2:0] body;
    body = {w, s, d, l};
    return {body, ~(^body)};
  endfunction

  task automatic do_sample(input logic [DW-1:0] p, input logic [DW-1:0] v);
    pos_live = p; vel_live = v;
    waitn(2);
    smp_strobe = 1'b0; waitn(HALF);
    smp_strobe = 1'b1; waitn(HALF);
  endtask

  // reads a frame; returns collected bits and tail of 3 extra bits
  task automatic read_frame(input bit flip_flags, output logic [FW-1:0] got,
                            output logic [2:0] tail, output logic oe_seen);
    cs_n = 1'b0; waitn(2);
    rd_n = 1'b0; waitn(HALF);
    oe_seen = sdo_oe;
    got[FW-1] = sdo;
    if (flip_flags) begin
      sel_pos = ~sel_pos; flt_degrade = ~flt_degrade; flt_trk_loss = ~flt_trk_loss;
    end
    for (int i = FW-2; i >= 0; i--) begin
      ser_clk = 1'b1; waitn(HALF);
      got[i] = sdo;
      ser_clk = 1'b0; waitn(HALF);
    end
    for (int i = 2; i >= 0; i--) begin
      ser_clk = 1'b1; waitn(HALF);
      tail[i] = sdo;
      ser_clk = 1'b0; waitn(HALF);
    end
    rd_n = 1'b1; waitn(HALF);
    cs_n = 1'b1; waitn(2);
  endtask

  initial begin
    logic [FW-1:0] got;
    logic [2:0]    tail;
    logic          oe_seen;
    logic [DW-1:0] p, v;
    logic          s, d, l;

    waitn(3);
    rst_n = 1'b1;
    waitn(4);
    // R10: idle after reset
    check("R10 oe after reset", sdo_oe, 1'b0);
    sel_pos = 1'b1;
    read_frame(1'b0, got, tail, oe_seen);
    check("R10 held position zero", got, mk_frame('0, 1'b1, 1'b0, 1'b0));
    sel_pos = 1'b0;
    read_frame(1'b0, got, tail, oe_seen);
    check("R10 held velocity zero", got, mk_frame('0, 1'b0, 1'b0, 1'b0));

    // R8: read with chip select high starts nothing
    cs_n = 1'b1; rd_n = 1'b0; waitn(HALF);
    check("R8 cs high read oe", sdo_oe, 1'b0);
    ser_clk = 1'b1; waitn(HALF); ser_clk = 1'b0; waitn(HALF);
    check("R8 cs high after clock oe", sdo_oe, 1'b0);
    rd_n = 1'b1; waitn(HALF);

    for (int k = 0; k < 40; k++) begin
      p = (k == 0) ? 12'h000 : (k == 1) ? 12'hFFF : (k == 2) ? 12'h800 :
          DW'((k * 32'h25F + k * k * 7) & 32'hFFF);
      v = (k == 0) ? 12'hFFF : (k == 1) ? 12'h000 : (k == 2) ? 12'h7FF :
          DW'(~p ^ DW'(k << 3));
      s = k[0]; d = k[1]; l = k[2];
      do_sample(p, v);
      // R1: live words move after the sample
      pos_live = ~p; vel_live = p ^ 12'h5A5;
      sel_pos = s; flt_degrade = d; flt_trk_loss = l;
      read_frame(1'b1, got, tail, oe_seen);
      // R2 R3 R4 R5 R6 R9 R1
      check("R5 oe after read edge", oe_seen, 1'b1);
      check("R1 R2 R3 R6 R9 frame", got, mk_frame(s ? p : v, s, d, l));
      check("R4 odd parity", 32'(^got), 1);
      check("R7 zero tail", tail, 3'b000);
      check("R8 oe off after read", sdo_oe, 1'b0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule